// File: doc/BRIEF.md
# Opcode Fetch Bus Cycle Sequencer

This block plays out one opcode-fetch machine cycle on the pins of an 8-bit processor bus. Its clock runs at twice the T-state rate, so each clock edge carries out one half-cycle of the bus protocol. There are eight half-cycle phases, T1-high through T4-low, and the phase index is the T-state number shifted left by one, ORed with one when the clock phase is low. The block drives a 16-bit address and the active-low strobes for the first machine cycle, memory request, read, refresh and halt. It samples the wait line, the bus request line and the data bus.

A pulse on `start` loads the cycle context: program counter, the I and R registers, and the halt flag. The block then reads the opcode from the PC address. In the second half of the same cycle it puts out the refresh address {I, R} and advances the low seven bits of R. At the end it gives back the next PC, the new R and the opcode, and raises `done`. When halting, the fetched byte is replaced by 0x00 and the PC is held. A bus request seen in T4 holds back `done` and raises `releasePending` until the request is dropped.

Top module: `fetch_cycle_seq`

## Requirements
- R1: While reset is asserted and after it is released with no start, all five strobes are high, `addr`, `opcode`, `pcOut` and `rOut` are zero, and `done` and `releasePending` are low.
- R2: The edge that accepts `start` performs T1-high. `addr` becomes `pcIn`, `m1N` goes low, `mreqN`, `rdN` and `rfshN` go high, and `haltN` is low exactly when `haltIn` was 1.
- R3: The T1-low edge drives `mreqN` and `rdN` low. The T2-high and T2-low edges change no pin.
- R4: At each T3-high edge `waitN` is sampled, active low. When it is low, no pin changes and the sequencer repeats T2-low and then T3-high. Each sampled wait therefore adds two clock edges, and a data value present during a wait is not latched.
- R5: At the T3-high edge with `waitN` high, `opcode` takes `dataIn`, or 0x00 when halting. At the same edge `m1N`, `mreqN` and `rdN` go high, `rfshN` goes low, and `addr` becomes {I, R} with I in bits 15:8.
- R6: The T3-low edge drives `mreqN` low. It also adds one to bits 6:0 of R, wrapping from 0x7F to 0x00, and keeps bit 7 unchanged. `addr` keeps the R value from before the increment.
- R7: The T4-high edge changes no pin. The T4-low edge drives `mreqN` high and sets `pcOut` to PC+1 modulo 2^16, or leaves PC unchanged when halting. `rfshN` stays low and `addr` stays {I, R} until the next cycle starts.
- R8: When `busReqN` is high at the T4-high edge, `done` is high for exactly the one clock after the T4-low edge.
- R9: When `busReqN` is low at the T4-high edge, `done` stays low after T4-low and `releasePending` goes high. The first edge that sees `busReqN` high clears `releasePending` and pulses `done` once. `busReqN` is ignored at every other phase of the cycle.
- R10: While a cycle is in progress, `start` and the context inputs (`pcIn`, `iIn`, `rIn`, `haltIn`) have no effect on the pins, `opcode`, `rOut` or `pcOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock, one edge per phase |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a fetch cycle when idle |
| haltIn | input | 1 | Halt flag for the cycle being started |
| pcIn | input | 16 | Program counter for the cycle |
| iIn | input | 8 | I register (refresh address high byte) |
| rIn | input | 8 | R register (refresh address low byte) |
| dataIn | input | 8 | Data bus input |
| waitN | input | 1 | Active-low wait request |
| busReqN | input | 1 | Active-low bus request |
| addr | output | 16 | Address bus |
| m1N | output | 1 | Active-low first-machine-cycle strobe |
| mreqN | output | 1 | Active-low memory request |
| rdN | output | 1 | Active-low read strobe |
| rfshN | output | 1 | Active-low refresh strobe |
| haltN | output | 1 | Active-low halt indicator |
| opcode | output | 8 | Fetched opcode (0x00 when halting) |
| pcOut | output | 16 | Program counter after the cycle |
| rOut | output | 8 | R register after the refresh increment |
| done | output | 1 | One-clock completion pulse |
| releasePending | output | 1 | Bus release request is being held |

## Verification
The hardest situations to reach are the cases where a line matters in one phase only. Wait is sampled only at the T3-high edge, and bus request only at the T4-high edge. The stimulus therefore drives the wait line low across whole stretched T-states while it changes the data bus. It drives bus request low through T1 to T3 and then raises it just before T4-high, so a sample taken in the wrong phase shows up. The context inputs are changed and `start` is held high in the middle of a cycle to show that nothing loads. R values 0x7F and 0xFF are applied directly, because random stimulus would rarely hit the refresh wrap with bit 7 in each state.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;

  // Half-cycle phase; the encoding is (T-state index << 1) | clock-low.
  typedef enum logic [2:0] {
    PH_T1H = 3'd0,
    PH_T1L = 3'd1,
    PH_T2H = 3'd2,
    PH_T2L = 3'd3,
    PH_T3H = 3'd4,
    PH_T3L = 3'd5,
    PH_T4H = 3'd6,
    PH_T4L = 3'd7
  } phase_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_HOLD = 2'd2
  } seq_e;

  // One-edge strobes from control to datapath.
  typedef struct packed {
    logic beginCycle;   // T1 high: load context, address = PC
    logic readStart;    // T1 low: memory read
    logic fetchLatch;   // T3 high, no wait: latch opcode, refresh address
    logic refreshStart; // T3 low: R increment, refresh request
    logic cycleEnd;     // T4 low: end refresh, PC step
  } fetchStrobes_t;

endpackage

// File: rtl/fetch_seq_ctrl.sv
module fetch_seq_ctrl
  import fetch_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          waitN,
  input  logic          busReqN,
  output fetchStrobes_t strobes,
  output logic          done,
  output logic          releasePending
);

  seq_e   seqState;
  phase_e nextPhase;
  logic   relReq;

  always_comb begin
    strobes = '0;
    unique case (seqState)
      SEQ_IDLE: strobes.beginCycle = start;
      SEQ_RUN: begin
        unique case (nextPhase)
          PH_T1L:  strobes.readStart    = 1'b1;
          PH_T3H:  strobes.fetchLatch   = waitN;
          PH_T3L:  strobes.refreshStart = 1'b1;
          PH_T4L:  strobes.cycleEnd     = 1'b1;
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqState       <= SEQ_IDLE;
      nextPhase      <= PH_T1H;
      relReq         <= 1'b0;
      done           <= 1'b0;
      releasePending <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (seqState)
        SEQ_IDLE: begin
          if (start) begin
            seqState  <= SEQ_RUN;
            nextPhase <= PH_T1L;
            relReq    <= 1'b0;
          end
        end
        SEQ_RUN: begin
          unique case (nextPhase)
            PH_T3H: nextPhase <= waitN ? PH_T3L : PH_T2L;
            PH_T4H: begin
              relReq    <= !busReqN;
              nextPhase <= PH_T4L;
            end
            PH_T4L: begin
              done           <= !relReq;
              releasePending <= relReq;
              seqState       <= relReq ? SEQ_HOLD : SEQ_IDLE;
              nextPhase      <= PH_T1H;
            end
            default: nextPhase <= phase_e'(nextPhase + 3'd1);
          endcase
        end
        SEQ_HOLD: begin
          if (busReqN) begin
            done           <= 1'b1;
            releasePending <= 1'b0;
            seqState       <= SEQ_IDLE;
          end
        end
        default: seqState <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fetch_seq_dp.sv
module fetch_seq_dp
  import fetch_seq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int RCNT_W  = 7,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetchStrobes_t     strobes,
  input  logic              haltIn,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [DATA_W-1:0] iIn,
  input  logic [DATA_W-1:0] rIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] addr,
  output logic              m1N,
  output logic              mreqN,
  output logic              rdN,
  output logic              rfshN,
  output logic              haltN,
  output logic [DATA_W-1:0] opcode,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] rOut
);

  logic [DATA_W-1:0] iReg;
  logic              haltFlag;
  logic [DATA_W-1:0] rStep;

  // Only the low RCNT_W bits of R count; the upper bits are held.
  assign rStep = {rOut[DATA_W-1:RCNT_W], RCNT_W'(rOut[RCNT_W-1:0] + 1'b1)};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr     <= '0;
      m1N      <= 1'b1;
      mreqN    <= 1'b1;
      rdN      <= 1'b1;
      rfshN    <= 1'b1;
      haltN    <= 1'b1;
      opcode   <= '0;
      pcOut    <= '0;
      rOut     <= '0;
      iReg     <= '0;
      haltFlag <= 1'b0;
    end else begin
      if (strobes.beginCycle) begin
        pcOut    <= pcIn;
        iReg     <= iIn;
        rOut     <= rIn;
        haltFlag <= haltIn;
        addr     <= pcIn;
        m1N      <= 1'b0;
        mreqN    <= 1'b1;
        rdN      <= 1'b1;
        rfshN    <= 1'b1;
        haltN    <= !haltIn;
      end
      if (strobes.readStart) begin
        mreqN <= 1'b0;
        rdN   <= 1'b0;
      end
      if (strobes.fetchLatch) begin
        opcode <= haltFlag ? '0 : dataIn;
        m1N    <= 1'b1;
        mreqN  <= 1'b1;
        rdN    <= 1'b1;
        rfshN  <= 1'b0;
        addr   <= {iReg, rOut};
      end
      if (strobes.refreshStart) begin
        rOut  <= rStep;
        mreqN <= 1'b0;
      end
      if (strobes.cycleEnd) begin
        mreqN <= 1'b1;
        if (!haltFlag) pcOut <= pcOut + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fetch_cycle_seq.sv
module fetch_cycle_seq
  import fetch_seq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int RCNT_W  = 7,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              haltIn,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [DATA_W-1:0] iIn,
  input  logic [DATA_W-1:0] rIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              waitN,
  input  logic              busReqN,
  output logic [ADDR_W-1:0] addr,
  output logic              m1N,
  output logic              mreqN,
  output logic              rdN,
  output logic              rfshN,
  output logic              haltN,
  output logic [DATA_W-1:0] opcode,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] rOut,
  output logic              done,
  output logic              releasePending
);

  fetchStrobes_t strobes;

  fetch_seq_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .start          (start),
    .waitN          (waitN),
    .busReqN        (busReqN),
    .strobes        (strobes),
    .done           (done),
    .releasePending (releasePending)
  );

  fetch_seq_dp #(.DATA_W(DATA_W), .RCNT_W(RCNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .haltIn  (haltIn),
    .pcIn    (pcIn),
    .iIn     (iIn),
    .rIn     (rIn),
    .dataIn  (dataIn),
    .addr    (addr),
    .m1N     (m1N),
    .mreqN   (mreqN),
    .rdN     (rdN),
    .rfshN   (rfshN),
    .haltN   (haltN),
    .opcode  (opcode),
    .pcOut   (pcOut),
    .rOut    (rOut)
  );

endmodule

// File: rtl/fetch_seq_checker.sv
module fetch_seq_checker #(
  parameter int DATA_W  = 8,
  parameter int RCNT_W  = 7,
  localparam int ADDR_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              m1N,
  input logic              mreqN,
  input logic              rdN,
  input logic              rfshN,
  input logic              haltN,
  input logic [ADDR_W-1:0] pcOut,
  input logic [DATA_W-1:0] rOut,
  input logic              done,
  input logic              releasePending
);

  // T1 high: a fresh M1 starts with the other strobes idle.
  assert_t1_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(m1N) |-> (mreqN && rdN && rfshN));

  // The read starts with M1 active and no refresh.
  assert_read_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdN) |-> (!m1N && !mreqN && rfshN));

  // Refresh begins only after the read strobes are released.
  assert_refresh_entry_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rfshN) |-> (m1N && rdN && mreqN));

  // Refresh request: the low R bits advance by one and the top bit is held.
  assert_r_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!rfshN && $fell(mreqN)) |->
      (rOut[RCNT_W-1:0] == RCNT_W'($past(rOut[RCNT_W-1:0]) + 1'b1)) &&
      (rOut[DATA_W-1:RCNT_W] == $past(rOut[DATA_W-1:RCNT_W])));

  // End of refresh: the PC steps, or holds while halting.
  assert_pc_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(mreqN) && $past(!rfshN)) |->
      (pcOut == (haltN ? ADDR_W'($past(pcOut) + 1'b1) : $past(pcOut))));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_vs_pending_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !releasePending);

endmodule

bind fetch_cycle_seq fetch_seq_checker #(.DATA_W(DATA_W), .RCNT_W(RCNT_W)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .m1N            (m1N),
  .mreqN          (mreqN),
  .rdN            (rdN),
  .rfshN          (rfshN),
  .haltN          (haltN),
  .pcOut          (pcOut),
  .rOut           (rOut),
  .done           (done),
  .releasePending (releasePending)
);

// File: tb/tb_fetch_cycle_seq.sv
module tb_fetch_cycle_seq;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic        haltIn;
  logic [15:0] pcIn;
  logic [7:0]  iIn;
  logic [7:0]  rIn;
  logic [7:0]  dataIn;
  logic        waitN;
  logic        busReqN;
  logic [15:0] addr;
  logic        m1N, mreqN, rdN, rfshN, haltN;
  logic [7:0]  opcode;
  logic [15:0] pcOut;
  logic [7:0]  rOut;
  logic        done;
  logic        releasePending;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fetch_cycle_seq dut (
    .clk(clk), .rstN(rstN), .start(start), .haltIn(haltIn), .pcIn(pcIn),
    .iIn(iIn), .rIn(rIn), .dataIn(dataIn), .waitN(waitN), .busReqN(busReqN),
    .addr(addr), .m1N(m1N), .mreqN(mreqN), .rdN(rdN), .rfshN(rfshN),
    .haltN(haltN), .opcode(opcode), .pcOut(pcOut), .rOut(rOut),
    .done(done), .releasePending(releasePending)
  );

  function automatic logic [7:0] refreshNext(input logic [7:0] r);
    return {r[7], 7'(r[6:0] + 7'd1)};
  endfunction

  function automatic logic [15:0] pcNext(input logic [15:0] pc, input bit hlt);
    return hlt ? pc : 16'(pc + 16'd1);
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pins(input string tag, input logic [15:0] a, input logic m1,
                      input logic mr, input logic rd, input logic rf, input logic h);
    cmp(tag, {11'd0, addr, m1N, mreqN, rdN, rfshN, haltN}, {11'd0, a, m1, mr, rd, rf, h});
  endtask

  task automatic edgeStep();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runCycle(input logic [15:0] pc, input logic [7:0] iv, input logic [7:0] rv,
                          input bit hlt, input logic [7:0] dat, input int nWait,
                          input int holdLen, input bit busyStart);
    logic        hN;
    logic [15:0] ir;
    hN = !hlt;
    ir = {iv, rv};
    start = 1'b1; pcIn = pc; iIn = iv; rIn = rv; haltIn = hlt;
    dataIn = ~dat; waitN = 1'($urandom); busReqN = 1'b0;
    edgeStep();
    pins("R2 T1-high pins", pc, 1'b0, 1'b1, 1'b1, 1'b1, hN);
    cmp("R8 no done at T1", {31'd0, done}, 32'd0);
    start = busyStart;
    if (busyStart) begin
      pcIn = ~pc; iIn = ~iv; rIn = ~rv; haltIn = !hlt;
    end
    edgeStep();
    pins("R3 T1-low pins", pc, 1'b0, 1'b0, 1'b0, 1'b1, hN);
    edgeStep();
    pins("R3 T2-high pins", pc, 1'b0, 1'b0, 1'b0, 1'b1, hN);
    edgeStep();
    pins("R3 T2-low pins", pc, 1'b0, 1'b0, 1'b0, 1'b1, hN);
    for (int w = 0; w < nWait; w++) begin
      waitN = 1'b0;
      dataIn = 8'($urandom);
      edgeStep();
      pins("R4 waited T3-high pins", pc, 1'b0, 1'b0, 1'b0, 1'b1, hN);
      waitN = 1'($urandom);
      edgeStep();
      pins("R4 repeated T2-low pins", pc, 1'b0, 1'b0, 1'b0, 1'b1, hN);
    end
    waitN = 1'b1;
    dataIn = dat;
    edgeStep();
    pins("R5 T3-high pins", ir, 1'b1, 1'b1, 1'b1, 1'b0, hN);
    cmp(busyStart ? "R5 R10 opcode" : "R5 opcode", {24'd0, opcode}, {24'd0, hlt ? 8'h00 : dat});
    waitN = 1'($urandom);
    dataIn = 8'($urandom);
    edgeStep();
    pins("R6 T3-low pins", ir, 1'b1, 1'b0, 1'b1, 1'b0, hN);
    cmp("R6 refresh register", {24'd0, rOut}, {24'd0, refreshNext(rv)});
    start = 1'b0;
    busReqN = (holdLen == 0);
    edgeStep();
    pins("R7 T4-high pins", ir, 1'b1, 1'b0, 1'b1, 1'b0, hN);
    if (holdLen > 0) busReqN = 1'($urandom);
    else busReqN = 1'b0;
    edgeStep();
    pins("R7 T4-low pins", ir, 1'b1, 1'b1, 1'b1, 1'b0, hN);
    cmp(busyStart ? "R7 R10 pc after cycle" : "R7 pc after cycle", {16'd0, pcOut}, {16'd0, pcNext(pc, hlt)});
    cmp("R8 done at T4-low", {31'd0, done}, {31'd0, holdLen == 0});
    cmp("R9 pending at T4-low", {31'd0, releasePending}, {31'd0, holdLen > 0});
    if (holdLen > 0) begin
      for (int h = 0; h < holdLen; h++) begin
        busReqN = 1'b0;
        edgeStep();
        cmp("R9 pending held", {31'd0, releasePending}, 32'd1);
        cmp("R9 done withheld", {31'd0, done}, 32'd0);
      end
      busReqN = 1'b1;
      edgeStep();
      cmp("R9 done on release", {31'd0, done}, 32'd1);
      cmp("R9 pending cleared", {31'd0, releasePending}, 32'd0);
    end
    busReqN = 1'b1;
    edgeStep();
    cmp("R8 done single pulse", {31'd0, done}, 32'd0);
    pins("R7 refresh held after cycle", ir, 1'b1, 1'b1, 1'b1, 1'b0, hN);
    cmp("R7 pc stays", {16'd0, pcOut}, {16'd0, pcNext(pc, hlt)});
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; start = 1'b0; haltIn = 1'b0; pcIn = 16'h0; iIn = 8'h0; rIn = 8'h0;
    dataIn = 8'h0; waitN = 1'b1; busReqN = 1'b1;
    repeat (3) edgeStep();
    pins("R1 pins in reset", 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    cmp("R1 flags in reset", {30'd0, done, releasePending}, 32'd0);
    rstN = 1'b1;
    edgeStep();
    edgeStep();
    pins("R1 pins idle", 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    cmp("R1 results idle", {opcode, pcOut, rOut}, 32'd0);
    cmp("R1 flags idle", {30'd0, done, releasePending}, 32'd0);

    runCycle(16'h1234, 8'h5A, 8'h10, 1'b0, 8'hC3, 0, 0, 1'b0);
    runCycle(16'h2000, 8'h3F, 8'h22, 1'b0, 8'h7E, 2, 0, 1'b0);
    runCycle(16'h4567, 8'h81, 8'h05, 1'b1, 8'hFF, 0, 0, 1'b0);
    runCycle(16'h4567, 8'h81, 8'h05, 1'b1, 8'hAA, 2, 0, 1'b0);
    runCycle(16'h0100, 8'h12, 8'h7F, 1'b0, 8'h01, 0, 0, 1'b0);
    runCycle(16'h0101, 8'h12, 8'hFF, 1'b0, 8'h02, 1, 0, 1'b0);
    runCycle(16'hFFFF, 8'hEE, 8'h80, 1'b0, 8'h3C, 0, 3, 1'b1);
    runCycle(16'h8000, 8'h00, 8'h41, 1'b0, 8'h55, 1, 1, 1'b0);

    for (int n = 0; n < 40; n++) begin
      runCycle(16'($urandom), 8'($urandom), 8'($urandom), 1'(($urandom % 4) == 0),
               8'($urandom), int'($urandom % 4), int'($urandom % 3), 1'($urandom));
    end

    finished = 1'b1;
    report();
    $finish;
  end

endmodule